// File: doc/BRIEF.md
# Pixel Arrival-Time and Pulse-Width Cell

This block is the digital half of a single pixel in a hybrid pixel detector readout matrix. While the acquisition window (`shutter`) is open, it watches one discriminator output. From the same event it takes two 4-bit measurements at once. The arrival time counts counting-clock cycles from the first rising edge of the event until the window closes. The pulse width counts the cycles for which that first pulse stays high. Both counters saturate at their maximum.

Each pixel keeps a small configuration word: a mask bit, a test-injection enable and a 4-bit threshold trim code for the in-pixel trim DAC. The configuration is shifted in serially through a chain that links each pixel to the one below and the one above it. A second chain carries hit data down the column. On a capture strobe every pixel freezes its result. A pixel that saw a hit then puts a 9-bit frame into the chain. A pixel without a hit puts in a single 0 bit, so the end-of-column logic can skip empty pixels at the cost of one bit each. The readout shift register moves only while the shift enable is asserted, which models the gated readout clock.

Top module: `pixel_tdc_cell`

## Requirements
- R1: While `rst_n` is low, and right after it is released, every register is cleared. This gives `rd_out`=0, `cfg_out`=0, `trim_code`=0, `pix_masked`=0 and `tp_enabled`=0.
- R2: On each clock with `cfg_load` high, `cfg_in` shifts into a 6-bit configuration word. The bit shifted in first ends in bit 5. Bit 5 is the mask, bit 4 is the test enable and bits 3..0 are the trim code. `cfg_out` is bit 5. With `cfg_load` low the word holds.
- R3: The hit flag is set only by a rising edge of the event while `shutter` is high. An edge while `shutter` is low does not set it. An event that is already high when `shutter` opens does not set it either.
- R4: The arrival-time count equals the number of clock edges with `shutter` high, counted from the hit edge inclusive, and saturates at 15.
- R5: The pulse-width count equals the number of clock edges, starting at the hit edge, for which the event stays high with `shutter` open, and saturates at 15. Pulses after the first do not change it.
- R6: With the mask bit set, neither `disc_in` nor `tp_pulse` can produce a hit.
- R7: With the test enable set, `tp_pulse` counts as an event just like `disc_in`. With it clear, `tp_pulse` is ignored.
- R8: `clear_cmd` clears both counts and the hit flag and leaves the configuration word unchanged.
- R9: `rd_load` captures the result. For a hit pixel, `rd_out` then shows a 1 header bit. Each following `rd_shift` clock then presents the next bit: first the arrival time MSB first, then the pulse width MSB first. The path from `rd_in` to `rd_out` is 9 stages long.
- R10: For a pixel without a hit, `rd_load` makes `rd_out`=0. After one `rd_shift` clock, `rd_out` shows the value `rd_in` had (a 1-stage path).
- R11: While `rd_shift` and `rd_load` are both low, `rd_out` holds its value whatever `rd_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, also used for the chains |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutter | input | 1 | Acquisition window |
| disc_in | input | 1 | Discriminator output (synchronous to clk) |
| tp_pulse | input | 1 | Injected test pulse |
| clear_cmd | input | 1 | Clears the measurements, keeps the configuration |
| cfg_load | input | 1 | Configuration shift enable |
| cfg_in | input | 1 | Configuration serial input from the neighbour |
| cfg_out | output | 1 | Configuration serial output to the next pixel |
| rd_load | input | 1 | Capture result into the readout register |
| rd_shift | input | 1 | Readout shift enable (gated readout clock) |
| rd_in | input | 1 | Readout serial input from the upstream pixel |
| rd_out | output | 1 | Readout serial output toward the periphery |
| trim_code | output | 4 | Threshold trim code for the trim DAC |
| pix_masked | output | 1 | Mask bit currently held |
| tp_enabled | output | 1 | Test-injection enable currently held |

## Verification
The bench builds the cell with its default 4-bit counters and 4-bit trim code. At that width, pulses and windows of 20 to 25 cycles push both counters into saturation. The 9-bit frame can then be read out whole, and its header, field order and bit order can be checked bit by bit. With 4-bit fields, a second pulse placed inside the same window, an event already high at the moment the window opens, and a configuration word shifted in full are all short enough to exercise directly.

// File: rtl/pixel_cell_pkg.sv
package pixel_cell_pkg;

   // Control bits of the per-pixel configuration word, MSB first in the chain.
   typedef struct packed {
      logic mask;
      logic tp_en;
   } pix_ctl_t;

   localparam int unsigned CTL_BITS = $bits(pix_ctl_t);

   // Length of a hit frame: one header bit plus two measurement fields.
   function automatic int unsigned frame_bits(input int unsigned cnt_w);
      return 1 + 2 * cnt_w;
   endfunction

endpackage

// File: rtl/pixel_cfg_chain.sv
module pixel_cfg_chain
   import pixel_cell_pkg::*;
#(
   parameter int unsigned TRIM_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              ser_in,
   output logic              ser_out,
   output pix_ctl_t          ctl,
   output logic [TRIM_W-1:0] trim
);

   localparam int unsigned CFG_W = CTL_BITS + TRIM_W;

   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (shift_en) begin
         cfg_q <= {cfg_q[CFG_W-2:0], ser_in};
      end
   end

   assign ser_out = cfg_q[CFG_W-1];
   assign ctl     = cfg_q[CFG_W-1 -: CTL_BITS];
   assign trim    = cfg_q[TRIM_W-1:0];

endmodule

// File: rtl/pixel_event_front.sv
module pixel_event_front
   import pixel_cell_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     disc_in,
   input  logic     tp_pulse,
   input  pix_ctl_t ctl,
   output logic     ev_level,
   output logic     ev_rise
);

   logic ev_q;

   // Injected pulse joins the discriminator only when enabled; mask kills both.
   assign ev_level = ~ctl.mask & (disc_in | (ctl.tp_en & tp_pulse));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q <= 1'b0;
      end else begin
         ev_q <= ev_level;
      end
   end

   assign ev_rise = ev_level & ~ev_q;

endmodule

// File: rtl/pixel_sat_counter.sv
module pixel_sat_counter #(
   parameter int unsigned W        = 4,
   parameter bit          SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load_one,
   input  logic         inc,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] TOP = {W{1'b1}};
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] nxt_inc;

   generate
      if (SATURATE) begin : g_sat
         assign nxt_inc = (q == TOP) ? TOP : q + ONE;
      end else begin : g_wrap
         assign nxt_inc = q + ONE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (clr) begin
         q <= '0;
      end else if (load_one) begin
         q <= ONE;
      end else if (inc) begin
         q <= nxt_inc;
      end
   end

endmodule

// File: rtl/pixel_meas_core.sv
module pixel_meas_core #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shutter,
   input  logic             ev_level,
   input  logic             ev_rise,
   output logic             hit,
   output logic [CNT_W-1:0] toa,
   output logic [CNT_W-1:0] tot
);

   logic hit_q;
   logic tot_run_q;
   logic start;

   assign start = shutter & ev_rise & ~hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q     <= 1'b0;
         tot_run_q <= 1'b0;
      end else if (clr) begin
         hit_q     <= 1'b0;
         tot_run_q <= 1'b0;
      end else begin
         if (start) begin
            hit_q <= 1'b1;
         end
         if (start) begin
            tot_run_q <= 1'b1;
         end else if (tot_run_q && !(ev_level && shutter)) begin
            tot_run_q <= 1'b0;
         end
      end
   end

   pixel_sat_counter #(.W(CNT_W), .SATURATE(1'b1)) toa_cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .load_one (start),
      .inc      (hit_q & shutter),
      .q        (toa)
   );

   pixel_sat_counter #(.W(CNT_W), .SATURATE(1'b1)) tot_cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .load_one (start),
      .inc      (tot_run_q & ev_level & shutter),
      .q        (tot)
   );

   assign hit = hit_q;

endmodule

// File: rtl/pixel_readout_sr.sv
module pixel_readout_sr
   import pixel_cell_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic             hit,
   input  logic [CNT_W-1:0] toa,
   input  logic [CNT_W-1:0] tot,
   input  logic             ser_in,
   output logic             ser_out
);

   localparam int unsigned FRAME_W = frame_bits(CNT_W);

   logic [FRAME_W-1:0] sr_q;
   logic               long_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         long_q <= 1'b0;
      end else if (load) begin
         long_q <= hit;
         sr_q   <= hit ? {1'b1, toa, tot} : '0;
      end else if (shift) begin
         sr_q   <= {sr_q[FRAME_W-2:0], ser_in};
      end
   end

   // Empty pixel: one-stage bypass; hit pixel: full frame length.
   assign ser_out = long_q ? sr_q[FRAME_W-1] : sr_q[0];

endmodule

// File: rtl/pixel_tdc_cell.sv
module pixel_tdc_cell
   import pixel_cell_pkg::*;
#(
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned TRIM_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shutter,
   input  logic              disc_in,
   input  logic              tp_pulse,
   input  logic              clear_cmd,
   input  logic              cfg_load,
   input  logic              cfg_in,
   output logic              cfg_out,
   input  logic              rd_load,
   input  logic              rd_shift,
   input  logic              rd_in,
   output logic              rd_out,
   output logic [TRIM_W-1:0] trim_code,
   output logic              pix_masked,
   output logic              tp_enabled
);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("pixel_tdc_cell: CNT_W must be within 2..16");
      end
      if (TRIM_W < 1 || TRIM_W > 8) begin : g_bad_trim
         $error("pixel_tdc_cell: TRIM_W must be within 1..8");
      end
   endgenerate

   pix_ctl_t         ctl_w;
   logic             ev_level_w;
   logic             ev_rise_w;
   logic             hit_w;
   logic [CNT_W-1:0] toa_w;
   logic [CNT_W-1:0] tot_w;

   pixel_cfg_chain #(.TRIM_W(TRIM_W)) cfg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cfg_load),
      .ser_in   (cfg_in),
      .ser_out  (cfg_out),
      .ctl      (ctl_w),
      .trim     (trim_code)
   );

   pixel_event_front evt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .disc_in  (disc_in),
      .tp_pulse (tp_pulse),
      .ctl      (ctl_w),
      .ev_level (ev_level_w),
      .ev_rise  (ev_rise_w)
   );

   pixel_meas_core #(.CNT_W(CNT_W)) meas_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clear_cmd),
      .shutter  (shutter),
      .ev_level (ev_level_w),
      .ev_rise  (ev_rise_w),
      .hit      (hit_w),
      .toa      (toa_w),
      .tot      (tot_w)
   );

   pixel_readout_sr #(.CNT_W(CNT_W)) rd_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (rd_load),
      .shift   (rd_shift),
      .hit     (hit_w),
      .toa     (toa_w),
      .tot     (tot_w),
      .ser_in  (rd_in),
      .ser_out (rd_out)
   );

   assign pix_masked = ctl_w.mask;
   assign tp_enabled = ctl_w.tp_en;

endmodule

// File: rtl/pixel_tdc_cell_chk.sv
module pixel_tdc_cell_chk #(
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned TRIM_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              shutter,
   input logic              clear_cmd,
   input logic              cfg_load,
   input logic              rd_load,
   input logic              rd_shift,
   input logic              rd_out,
   input logic [TRIM_W-1:0] trim_code,
   input logic              pix_masked,
   input logic              hit_q,
   input logic [CNT_W-1:0]  toa_q,
   input logic [CNT_W-1:0]  tot_q
);

   assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> $stable(trim_code));

   assert_no_count_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!shutter && !clear_cmd) |=> $stable(toa_q));

   assert_toa_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_cmd |=> toa_q >= $past(toa_q));

   assert_width_within_toa_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tot_q <= toa_q);

   assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_masked && !hit_q) |=> !hit_q);

   assert_hit_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && !clear_cmd) |=> hit_q);

   assert_clear_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clear_cmd |=> (!hit_q && toa_q == '0 && tot_q == '0));

   assert_rd_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_shift && !rd_load) |=> $stable(rd_out));

endmodule

bind pixel_tdc_cell pixel_tdc_cell_chk #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .shutter    (shutter),
   .clear_cmd  (clear_cmd),
   .cfg_load   (cfg_load),
   .rd_load    (rd_load),
   .rd_shift   (rd_shift),
   .rd_out     (rd_out),
   .trim_code  (trim_code),
   .pix_masked (pix_masked),
   .hit_q      (hit_w),
   .toa_q      (toa_w),
   .tot_q      (tot_w)
);

// File: tb/pixel_tdc_cell_tb_top.sv
module pixel_tdc_cell_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       shutter = 1'b0;
   logic       disc_in = 1'b0;
   logic       tp_pulse = 1'b0;
   logic       clear_cmd = 1'b0;
   logic       cfg_load = 1'b0;
   logic       cfg_in = 1'b0;
   logic       cfg_out;
   logic       rd_load = 1'b0;
   logic       rd_shift = 1'b0;
   logic       rd_in = 1'b0;
   logic       rd_out;
   logic [3:0] trim_code;
   logic       pix_masked;
   logic       tp_enabled;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pixel_tdc_cell dut_i (
      .clk(clk), .rst_n(rst_n), .shutter(shutter), .disc_in(disc_in),
      .tp_pulse(tp_pulse), .clear_cmd(clear_cmd), .cfg_load(cfg_load),
      .cfg_in(cfg_in), .cfg_out(cfg_out), .rd_load(rd_load),
      .rd_shift(rd_shift), .rd_in(rd_in), .rd_out(rd_out),
      .trim_code(trim_code), .pix_masked(pix_masked), .tp_enabled(tp_enabled)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load_cfg(input bit m, input bit t, input logic [3:0] tr);
      logic [5:0] word;
      word = {m, t, tr};
      cfg_load = 1'b1;
      for (int i = 5; i >= 0; i--) begin
         cfg_in = word[i];
         @(negedge clk);
      end
      cfg_load = 1'b0;
      cfg_in = 1'b0;
   endtask

   task automatic do_clear();
      clear_cmd = 1'b1;
      @(negedge clk);
      clear_cmd = 1'b0;
   endtask

   // Window of s edges from the hit edge; source high for c < p1 and
   // p1+gap <= c < p1+gap+p2.
   task automatic acquire(input int s, input int p1, input int gap,
                          input int p2, input bit use_tp);
      bit src;
      shutter = 1'b1;
      repeat (2) @(negedge clk);
      for (int c = 0; c < s; c++) begin
         src = (c < p1) || (c >= p1 + gap && c < p1 + gap + p2);
         if (use_tp) tp_pulse = src; else disc_in = src;
         @(negedge clk);
      end
      shutter = 1'b0;
      disc_in = 1'b0;
      tp_pulse = 1'b0;
      @(negedge clk);
   endtask

   task automatic read_frame(output bit hdr, output int toa, output int tot);
      logic [7:0] bits;
      rd_load = 1'b1;
      @(negedge clk);
      rd_load = 1'b0;
      hdr = rd_out;
      bits = '0;
      if (hdr) begin
         for (int i = 7; i >= 0; i--) begin
            rd_shift = 1'b1;
            @(negedge clk);
            rd_shift = 1'b0;
            bits[i] = rd_out;
         end
      end
      toa = int'(bits[7:4]);
      tot = int'(bits[3:0]);
   endtask

   task automatic expect_hit(input string req, input int etoa, input int etot);
      bit h; int a; int b;
      read_frame(h, a, b);
      check({req, " header"}, int'(h), 1);
      check({req, " arrival"}, a, etoa);
      check({req, " width"}, b, etot);
   endtask

   task automatic expect_empty(input string req);
      bit h; int a; int b;
      read_frame(h, a, b);
      check({req, " empty header"}, int'(h), 0);
   endtask

   task automatic t_reset();
      check("R1 rd_out", int'(rd_out), 0);
      check("R1 cfg_out", int'(cfg_out), 0);
      check("R1 trim", int'(trim_code), 0);
      check("R1 mask", int'(pix_masked), 0);
      check("R1 tp_en", int'(tp_enabled), 0);
   endtask

   task automatic t_config();
      load_cfg(1'b1, 1'b0, 4'hB);
      check("R2 trim", int'(trim_code), 11);
      check("R2 mask", int'(pix_masked), 1);
      check("R2 tp_en", int'(tp_enabled), 0);
      check("R2 cfg_out", int'(cfg_out), 1);
      cfg_in = 1'b0;
      repeat (3) begin
         cfg_in = ~cfg_in;
         @(negedge clk);
      end
      cfg_in = 1'b0;
      check("R2 hold trim", int'(trim_code), 11);
      check("R2 hold mask", int'(pix_masked), 1);
      load_cfg(1'b0, 1'b1, 4'h6);
      check("R2 trim2", int'(trim_code), 6);
      check("R2 tp_en2", int'(tp_enabled), 1);
      load_cfg(1'b0, 1'b0, 4'h3);
   endtask

   task automatic t_basic();
      do_clear();
      acquire(7, 3, 0, 0, 1'b0);
      expect_hit("R4 R5 R9 basic", 7, 3);
      do_clear();
      acquire(12, 12, 0, 0, 1'b0);
      expect_hit("R4 R5 full", 12, 12);
   endtask

   task automatic t_saturate();
      do_clear();
      acquire(25, 20, 0, 0, 1'b0);
      expect_hit("R4 R5 saturation", 15, 15);
   endtask

   task automatic t_second_pulse();
      do_clear();
      acquire(10, 2, 2, 5, 1'b0);
      expect_hit("R5 second pulse", 10, 2);
   endtask

   task automatic t_edges_outside();
      do_clear();
      // Edge while the window is closed.
      disc_in = 1'b1;
      repeat (2) @(negedge clk);
      disc_in = 1'b0;
      repeat (2) @(negedge clk);
      // Event already high when the window opens.
      disc_in = 1'b1;
      @(negedge clk);
      shutter = 1'b1;
      repeat (5) @(negedge clk);
      shutter = 1'b0;
      disc_in = 1'b0;
      @(negedge clk);
      expect_empty("R3 no edge in window");
   endtask

   task automatic t_mask();
      load_cfg(1'b1, 1'b1, 4'h3);
      do_clear();
      acquire(6, 3, 0, 0, 1'b0);
      expect_empty("R6 masked disc");
      do_clear();
      acquire(6, 3, 0, 0, 1'b1);
      expect_empty("R6 masked test pulse");
      load_cfg(1'b0, 1'b0, 4'h3);
   endtask

   task automatic t_test_pulse();
      load_cfg(1'b0, 1'b1, 4'h9);
      do_clear();
      acquire(5, 4, 0, 0, 1'b1);
      expect_hit("R7 injected", 5, 4);
      load_cfg(1'b0, 1'b0, 4'h9);
      do_clear();
      acquire(5, 4, 0, 0, 1'b1);
      expect_empty("R7 injection disabled");
   endtask

   task automatic t_clear();
      load_cfg(1'b0, 1'b0, 4'hA);
      do_clear();
      acquire(6, 3, 0, 0, 1'b0);
      do_clear();
      expect_empty("R8 cleared");
      check("R8 config kept", int'(trim_code), 10);
   endtask

   task automatic t_bypass_and_gate();
      do_clear();
      rd_load = 1'b1;
      @(negedge clk);
      rd_load = 1'b0;
      check("R10 empty bit", int'(rd_out), 0);
      rd_in = 1'b1;
      rd_shift = 1'b1;
      @(negedge clk);
      rd_shift = 1'b0;
      check("R10 one-stage pass", int'(rd_out), 1);
      rd_in = 1'b0;
      // Hit frame: header held while shifting is gated off.
      acquire(4, 2, 0, 0, 1'b0);
      rd_load = 1'b1;
      @(negedge clk);
      rd_load = 1'b0;
      repeat (3) begin
         rd_in = ~rd_in;
         @(negedge clk);
      end
      check("R11 gated hold", int'(rd_out), 1);
      // Nine-stage path: a 1 fed in appears after 9 shifts.
      rd_in = 1'b1;
      rd_shift = 1'b1;
      @(negedge clk);
      rd_in = 1'b0;
      repeat (7) @(negedge clk);
      check("R9 before ninth shift", int'(rd_out), 0);
      @(negedge clk);
      rd_shift = 1'b0;
      check("R9 nine-stage pass", int'(rd_out), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_config();
      t_basic();
      t_saturate();
      t_second_pulse();
      t_edges_outside();
      t_mask();
      t_test_pulse();
      t_clear();
      t_bypass_and_gate();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule